// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one DMA channel that copies memory to memory (or to and from a fixed device address) under the control of a chain of descriptors held in memory. Software writes the address of the first descriptor and then sets the enable bit. The channel reads a six-word descriptor and moves the byte count it names, one beat at a time. Each beat is a read from the source side followed by a write to the destination side, over a single request/acknowledge memory port. It then follows the descriptor's link word. A fixed end marker stops the chain.

Each side has its own width code and address mode in a packed config word. The current source address, the current destination address and the bytes still to move can be read back at any time. Software can pause the channel without losing progress, or halt it. Three one-cycle event pulses report half of a descriptor moved, a descriptor finished, and the whole chain finished. They are meant to feed an interrupt controller.

Top module: `ldma_channel`

## Requirements
- R1: After reset every register reads 0, `mem_req` is low and no event pulses.
- R2: Register offsets are fixed: enable 0x00 (bit 0), pause 0x04 (bit 0), chain start pointer 0x08 (read/write), then read-only views of the current descriptor: config 0x0C, current source 0x10, current destination 0x14, bytes left 0x18, parameter 0x1C. Writing 1 to enable starts the chain only while the channel is idle.
- R3: A descriptor is six 32-bit little-endian words read as word accesses (`mem_size` 2) at pointer, pointer+4 … pointer+20. Their order is: config, source address, destination address, byte count, parameter, link.
- R4: Config bits 26:25 give the destination width code and bits 10:9 give the source width code (0 = 1 byte, 1 = 2, 2 = 4, 3 treated as 4). A beat moves the narrower of the two, or 1 byte when fewer bytes remain than that. Data travels right-justified on `mem_rdata`/`mem_wdata`, with `mem_size` equal to the beat's code.
- R5: Address mode bits 22:21 (destination) and 6:5 (source) work as follows. Mode 0 advances that side's address by the beat size after each beat. Any other mode holds the address fixed.
- R6: Bytes left loads from the descriptor count and drops by the beat size on each write. The descriptor is done at zero. A count of 0 issues no data access.
- R7: A link value other than 0xFFFFF800 makes the channel fetch the next descriptor there. The value 0xFFFFF800 ends the chain, and enable then reads 0.
- R8: `evt_pkg` pulses once per finished descriptor. `evt_queue` pulses together with the last `evt_pkg`. `evt_half` pulses once per non-empty descriptor, on the beat where bytes left first becomes no more than half the count (rounded down).
- R9: Parameter bits 7:0 give a number of idle cycles the channel inserts after each destination write before the next source read of the same descriptor.
- R10: While pause bit 0 is set, no new request starts and progress is held. Clearing it resumes the chain to the same final result.
- R11: Writing 0 to enable halts the channel. Once any outstanding request completes, no further request or event occurs, progress registers keep their values, and a later start works.
- R12: Once raised, `mem_req` with its address, write flag, size and write data stays stable until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_size | output | 2 | Access size code (0 = 1 B, 1 = 2 B, 2 = 4 B) |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data, right-justified |
| evt_half | output | 1 | Half of a descriptor moved |
| evt_pkg | output | 1 | Descriptor finished |
| evt_queue | output | 1 | Chain finished |

## Verification
The hardest conditions to reach are a pause or a halt that lands while a request is stalled, and tail beats whose size differs from the body of the descriptor. The memory model in the bench withholds acknowledge on random cycles. Random descriptors mix all width codes and modes with byte counts that are not multiples of the beat, so that 1-byte tail beats follow wider ones. Directed runs time the pause and halt writes against an immediately acknowledging memory, and measure the idle gaps produced by the wait field.

// File: rtl/ldma_pkg.sv
package ldma_pkg;

  localparam int WORD_W = 32;
  localparam int OFFS_W = 5;
  localparam int GAP_W  = 8;

  localparam logic [OFFS_W-1:0] OFF_EN    = 5'h00;
  localparam logic [OFFS_W-1:0] OFF_PAUSE = 5'h04;
  localparam logic [OFFS_W-1:0] OFF_START = 5'h08;
  localparam logic [OFFS_W-1:0] OFF_CFG   = 5'h0C;
  localparam logic [OFFS_W-1:0] OFF_SRC   = 5'h10;
  localparam logic [OFFS_W-1:0] OFF_DST   = 5'h14;
  localparam logic [OFFS_W-1:0] OFF_LEFT  = 5'h18;
  localparam logic [OFFS_W-1:0] OFF_PARAM = 5'h1C;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RD,
    ST_WR,
    ST_GAP
  } ldma_state_e;

  // narrower side width, clamped to a word, shrunk to a byte for tails
  function automatic logic [1:0] beat_code(input logic [1:0] sw,
                                           input logic [1:0] dw,
                                           input logic [WORD_W-1:0] left);
    logic [1:0] c;
    c = (sw < dw) ? sw : dw;
    if (c == 2'd3) c = 2'd2;
    if (left < (32'd1 << c)) c = 2'd0;
    return c;
  endfunction

endpackage

// File: rtl/ldma_addr_step.sv
module ldma_addr_step #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    mode,
  input  logic [AW-1:0] step,
  output logic [AW-1:0] nxt
);

  always_comb begin
    if (mode == 2'd0) nxt = addr + step;
    else              nxt = addr;
  end

endmodule

// File: rtl/ldma_regs.sv
module ldma_regs
  import ldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [OFFS_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              chain_end,
  input  logic [WORD_W-1:0] cur_cfg,
  input  logic [WORD_W-1:0] cur_src,
  input  logic [WORD_W-1:0] cur_dst,
  input  logic [WORD_W-1:0] cur_left,
  input  logic [WORD_W-1:0] cur_param,
  output logic              en,
  output logic              pause,
  output logic [WORD_W-1:0] start_addr,
  output logic              go
);

  logic              en_q, en_d;
  logic              pause_q, pause_d;
  logic [WORD_W-1:0] start_q, start_d;

  always_comb begin
    en_d    = en_q;
    pause_d = pause_q;
    start_d = start_q;
    go      = 1'b0;
    if (reg_wr) begin
      case (reg_addr)
        OFF_EN: begin
          if (!reg_wdata[0]) en_d = 1'b0;
          else if (!busy) begin
            en_d = 1'b1;
            go   = 1'b1;
          end
        end
        OFF_PAUSE: pause_d = reg_wdata[0];
        OFF_START: start_d = reg_wdata;
        default: ;
      endcase
    end
    if (chain_end) en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      pause_q <= 1'b0;
      start_q <= '0;
    end else begin
      en_q    <= en_d;
      pause_q <= pause_d;
      start_q <= start_d;
    end
  end

  always_comb begin
    case (reg_addr)
      OFF_EN:    reg_rdata = {{(WORD_W-1){1'b0}}, en_q};
      OFF_PAUSE: reg_rdata = {{(WORD_W-1){1'b0}}, pause_q};
      OFF_START: reg_rdata = start_q;
      OFF_CFG:   reg_rdata = cur_cfg;
      OFF_SRC:   reg_rdata = cur_src;
      OFF_DST:   reg_rdata = cur_dst;
      OFF_LEFT:  reg_rdata = cur_left;
      OFF_PARAM: reg_rdata = cur_param;
      default:   reg_rdata = '0;
    endcase
  end

  assign en         = en_q;
  assign pause      = pause_q;
  assign start_addr = start_q;

endmodule

// File: rtl/ldma_seq.sv
module ldma_seq
  import ldma_pkg::*;
#(
  parameter logic [WORD_W-1:0] END_MARK = 32'hFFFF_F800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              pause,
  input  logic              go,
  input  logic [WORD_W-1:0] start_addr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] cur_cfg,
  output logic [WORD_W-1:0] cur_src,
  output logic [WORD_W-1:0] cur_dst,
  output logic [WORD_W-1:0] cur_left,
  output logic [WORD_W-1:0] cur_param,
  output logic              busy,
  output logic              chain_end,
  output logic              evt_half,
  output logic              evt_pkg,
  output logic              evt_queue
);

  localparam int IDX_W    = 3;
  localparam int LAST_IDX = 5;

  ldma_state_e       st_q, st_d;
  logic [IDX_W-1:0]  widx_q, widx_d;
  logic [WORD_W-1:0] ptr_q, ptr_d;
  logic [WORD_W-1:0] cfg_q, cfg_d;
  logic [WORD_W-1:0] src_q, src_d;
  logic [WORD_W-1:0] dst_q, dst_d;
  logic [WORD_W-1:0] left_q, left_d;
  logic [WORD_W-1:0] thr_q, thr_d;
  logic [WORD_W-1:0] param_q, param_d;
  logic [WORD_W-1:0] nx_q, nx_d;
  logic [WORD_W-1:0] buf_q, buf_d;
  logic [GAP_W-1:0]  gap_q, gap_d;
  logic              held_q;
  logic              half_q, half_d;
  logic              pkg_q, pkg_d;
  logic              queue_q, queue_d;

  logic              fetching, want_req, fire;
  logic [1:0]        bcode;
  logic [WORD_W-1:0] beat_b, beat_mask, src_nxt, dst_nxt, left_sub;
  logic              fin;
  logic [WORD_W-1:0] fin_nx;

  assign fetching = (st_q == ST_FETCH);
  assign want_req = (st_q == ST_FETCH) || (st_q == ST_RD) || (st_q == ST_WR);
  assign mem_req  = want_req && ((en && !pause) || held_q);
  assign fire     = mem_req && mem_ack;

  assign bcode     = beat_code(cfg_q[10:9], cfg_q[26:25], left_q);
  assign beat_b    = 32'd1 << bcode;
  assign beat_mask = (bcode == 2'd0) ? 32'h0000_00FF :
                     (bcode == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign left_sub  = left_q - beat_b;

  assign mem_we    = (st_q == ST_WR);
  assign mem_size  = fetching ? 2'd2 : bcode;
  assign mem_addr  = fetching ? ptr_q + {{(WORD_W-IDX_W-2){1'b0}}, widx_q, 2'b00}
                   : ((st_q == ST_WR) ? dst_q : src_q);
  assign mem_wdata = buf_q;

  ldma_addr_step #(.AW(WORD_W)) u_src_step (
    .addr(src_q), .mode(cfg_q[6:5]), .step(beat_b), .nxt(src_nxt)
  );
  ldma_addr_step #(.AW(WORD_W)) u_dst_step (
    .addr(dst_q), .mode(cfg_q[22:21]), .step(beat_b), .nxt(dst_nxt)
  );

  always_comb begin
    st_d      = st_q;
    widx_d    = widx_q;
    ptr_d     = ptr_q;
    cfg_d     = cfg_q;
    src_d     = src_q;
    dst_d     = dst_q;
    left_d    = left_q;
    thr_d     = thr_q;
    param_d   = param_q;
    nx_d      = nx_q;
    buf_d     = buf_q;
    gap_d     = gap_q;
    half_d    = 1'b0;
    pkg_d     = 1'b0;
    queue_d   = 1'b0;
    chain_end = 1'b0;
    fin       = 1'b0;
    fin_nx    = nx_q;

    if (st_q != ST_IDLE && !en && !held_q) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (go) begin
            ptr_d  = start_addr;
            widx_d = '0;
            st_d   = ST_FETCH;
          end
        end
        ST_FETCH: begin
          if (fire) begin
            widx_d = widx_q + 1'b1;
            case (widx_q)
              3'd0: cfg_d = mem_rdata;
              3'd1: src_d = mem_rdata;
              3'd2: dst_d = mem_rdata;
              3'd3: begin
                left_d = mem_rdata;
                thr_d  = mem_rdata >> 1;
              end
              3'd4: param_d = mem_rdata;
              default: begin
                nx_d = mem_rdata;
                if (left_q == '0) begin
                  fin    = 1'b1;
                  fin_nx = mem_rdata;
                end else begin
                  st_d = ST_RD;
                end
              end
            endcase
          end
        end
        ST_RD: begin
          if (fire) begin
            buf_d = mem_rdata & beat_mask;
            st_d  = ST_WR;
          end
        end
        ST_WR: begin
          if (fire) begin
            left_d = left_sub;
            src_d  = src_nxt;
            dst_d  = dst_nxt;
            if (left_q > thr_q && left_sub <= thr_q) half_d = 1'b1;
            if (left_sub == '0) begin
              fin = 1'b1;
            end else if (param_q[GAP_W-1:0] == '0) begin
              st_d = ST_RD;
            end else begin
              gap_d = param_q[GAP_W-1:0] - 1'b1;
              st_d  = ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (!pause) begin
            if (gap_q == '0) st_d = ST_RD;
            else             gap_d = gap_q - 1'b1;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end

    if (fin) begin
      pkg_d = 1'b1;
      if (fin_nx == END_MARK) begin
        queue_d   = 1'b1;
        chain_end = 1'b1;
        st_d      = ST_IDLE;
      end else begin
        ptr_d  = fin_nx;
        widx_d = '0;
        st_d   = ST_FETCH;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      widx_q  <= '0;
      ptr_q   <= '0;
      cfg_q   <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      left_q  <= '0;
      thr_q   <= '0;
      param_q <= '0;
      nx_q    <= '0;
      buf_q   <= '0;
      gap_q   <= '0;
      held_q  <= 1'b0;
      half_q  <= 1'b0;
      pkg_q   <= 1'b0;
      queue_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      widx_q  <= widx_d;
      ptr_q   <= ptr_d;
      cfg_q   <= cfg_d;
      src_q   <= src_d;
      dst_q   <= dst_d;
      left_q  <= left_d;
      thr_q   <= thr_d;
      param_q <= param_d;
      nx_q    <= nx_d;
      buf_q   <= buf_d;
      gap_q   <= gap_d;
      held_q  <= mem_req && !mem_ack;
      half_q  <= half_d;
      pkg_q   <= pkg_d;
      queue_q <= queue_d;
    end
  end

  assign cur_cfg   = cfg_q;
  assign cur_src   = src_q;
  assign cur_dst   = dst_q;
  assign cur_left  = left_q;
  assign cur_param = param_q;
  assign busy      = (st_q != ST_IDLE);
  assign evt_half  = half_q;
  assign evt_pkg   = pkg_q;
  assign evt_queue = queue_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_size) && $stable(mem_wdata))); // R12

  AST_PAUSE_NO_NEW_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !mem_req) |=> (!mem_req || !pause)); // R10

  AST_LEFT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_FETCH) |=> (left_q <= $past(left_q))); // R6

  AST_PKG_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pkg |-> (left_q == '0)); // R6

endmodule

// File: rtl/ldma_channel.sv
module ldma_channel
  import ldma_pkg::*;
#(
  parameter logic [31:0] END_MARK = 32'hFFFF_F800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [4:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [1:0]  mem_size,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        evt_half,
  output logic        evt_pkg,
  output logic        evt_queue
);

  logic              en_w, pause_w, go_w, busy_w, chain_end_w;
  logic [WORD_W-1:0] start_w, cfg_w, src_w, dst_w, left_w, param_w;

  ldma_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy(busy_w), .chain_end(chain_end_w),
    .cur_cfg(cfg_w), .cur_src(src_w), .cur_dst(dst_w),
    .cur_left(left_w), .cur_param(param_w),
    .en(en_w), .pause(pause_w), .start_addr(start_w), .go(go_w)
  );

  ldma_seq #(.END_MARK(END_MARK)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .en(en_w), .pause(pause_w), .go(go_w), .start_addr(start_w),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .cur_cfg(cfg_w), .cur_src(src_w), .cur_dst(dst_w),
    .cur_left(left_w), .cur_param(param_w),
    .busy(busy_w), .chain_end(chain_end_w),
    .evt_half(evt_half), .evt_pkg(evt_pkg), .evt_queue(evt_queue)
  );

  AST_QUEUE_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    evt_queue |-> !en_w); // R7

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_w && !mem_req) |=> (!mem_req || en_w)); // R11

endmodule

// File: tb/ldma_channel_test.sv
module ldma_channel_test;

  localparam logic [31:0] END_MARK = 32'hFFFF_F800;
  localparam int MEMSZ = 4096;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [1:0]  mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        evt_half, evt_pkg, evt_queue;

  ldma_channel uut (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .evt_half(evt_half), .evt_pkg(evt_pkg), .evt_queue(evt_queue)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]  mem  [MEMSZ];
  logic [7:0]  gold [MEMSZ];
  int          n_chk, n_fail;
  int          c_half, c_pkg, c_queue, c_wr;
  bit          stall_en;

  logic [31:0] dc_cfg [4];
  logic [31:0] dc_src [4];
  logic [31:0] dc_dst [4];
  logic [31:0] dc_cnt [4];
  logic [31:0] dc_par [4];
  logic [31:0] exp_src, exp_dst;

  // memory model: decides acknowledge after inputs have settled
  always @(negedge clk) begin
    #1;
    mem_ack   = 1'b0;
    mem_rdata = '0;
    if (mem_req && (!stall_en || ($urandom % 4 != 0))) begin
      mem_ack = 1'b1;
      for (int b = 0; b < (1 << mem_size); b++) begin
        if (mem_we) mem[(mem_addr + b) % MEMSZ] = mem_wdata[8*b +: 8];
        else        mem_rdata[8*b +: 8] = mem[(mem_addr + b) % MEMSZ];
      end
      if (mem_we) c_wr++;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      c_half  += int'(evt_half);
      c_pkg   += int'(evt_pkg);
      c_queue += int'(evt_queue);
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #2;
    v = reg_rdata;
  endtask

  function automatic logic [31:0] mk_cfg(input int dw, input int dm, input int sw,
                                         input int sm);
    logic [31:0] c;
    c = $urandom & 32'h0198_0198;          // burst and request-type fields: don't care
    c[26:25] = 2'(dw); c[22:21] = 2'(dm);
    c[10:9]  = 2'(sw); c[6:5]   = 2'(sm);
    return c;
  endfunction

  task automatic put_word(input int a, input logic [31:0] w);
    for (int b = 0; b < 4; b++) begin
      mem[(a + b) % MEMSZ]  = w[8*b +: 8];
      gold[(a + b) % MEMSZ] = w[8*b +: 8];
    end
  endtask

  // expected result of one descriptor, beat by beat, from R4/R5/R6
  task automatic gold_desc(input int i);
    logic [31:0] s, d, left;
    int code, nb;
    logic [7:0] tmp [4];
    s = dc_src[i]; d = dc_dst[i]; left = dc_cnt[i];
    while (left != 0) begin
      code = (dc_cfg[i][10:9] < dc_cfg[i][26:25]) ? int'(dc_cfg[i][10:9]) : int'(dc_cfg[i][26:25]);
      if (code == 3) code = 2;
      if (left < (32'd1 << code)) code = 0;
      nb = 1 << code;
      for (int b = 0; b < nb; b++) tmp[b] = gold[(s + b) % MEMSZ];
      for (int b = 0; b < nb; b++) gold[(d + b) % MEMSZ] = tmp[b];
      left = left - nb;
      if (dc_cfg[i][6:5] == 2'd0)   s = s + nb;
      if (dc_cfg[i][22:21] == 2'd0) d = d + nb;
    end
    exp_src = s; exp_dst = d;
  endtask

  task automatic load_chain(input int n);
    for (int i = 0; i < n; i++) begin
      put_word(i*32 + 0,  dc_cfg[i]);
      put_word(i*32 + 4,  dc_src[i]);
      put_word(i*32 + 8,  dc_dst[i]);
      put_word(i*32 + 12, dc_cnt[i]);
      put_word(i*32 + 16, dc_par[i]);
      put_word(i*32 + 20, (i == n-1) ? END_MARK : 32'(i*32 + 32));
      gold_desc(i);
    end
  endtask

  task automatic start_chain();
    wr(5'h08, 32'h0);
    c_half = 0; c_pkg = 0; c_queue = 0; c_wr = 0;
    wr(5'h00, 32'h1);
  endtask

  task automatic wait_queue(output int idle);
    idle = 0;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      #2;
      if (evt_queue) break;
      if (!mem_req) idle++;
    end
  endtask

  task automatic verify_chain(input int n, input string tag);
    logic [31:0] v;
    int bad, first;
    bad = 0; first = -1;
    repeat (2) @(negedge clk);
    for (int a = 12'h800; a < MEMSZ; a++)
      if (mem[a] !== gold[a]) begin bad++; if (first < 0) first = a; end
    check(bad == 0, {tag, " R4 R5 destination bytes"}, 32'(first), 32'hFFFFFFFF);
    check(c_pkg == n, {tag, " R8 package-end count"}, 32'(c_pkg), 32'(n));
    check(c_queue == 1, {tag, " R8 queue-end count"}, 32'(c_queue), 32'd1);
    rd(5'h00, v); check(v == 0, {tag, " R7 enable after end"}, v, 32'h0);
    rd(5'h18, v); check(v == 0, {tag, " R6 bytes left"}, v, 32'h0);
    rd(5'h10, v); check(v == exp_src, {tag, " R5 current source"}, v, exp_src);
    rd(5'h14, v); check(v == exp_dst, {tag, " R5 current destination"}, v, exp_dst);
    rd(5'h0C, v); check(v == dc_cfg[n-1], {tag, " R3 config view"}, v, dc_cfg[n-1]);
    rd(5'h1C, v); check(v == dc_par[n-1], {tag, " R3 parameter view"}, v, dc_par[n-1]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2, l1, l2;
    int idle, nreq;
    void'($urandom(32'h0000_51ED));
    n_chk = 0; n_fail = 0; stall_en = 1'b0;
    c_half = 0; c_pkg = 0; c_queue = 0; c_wr = 0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    mem_ack = 1'b0; mem_rdata = '0;
    for (int a = 0; a < MEMSZ; a++) begin
      mem[a] = 8'($urandom); gold[a] = mem[a];
    end
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int o = 0; o < 8; o++) begin
      rd(5'(o*4), v);
      check(v == 0, "R1 register after reset", v, 32'h0);
    end
    check(!mem_req && !evt_pkg && !evt_queue && !evt_half, "R1 outputs idle",
          {29'b0, mem_req, evt_pkg, evt_queue}, 32'h0);

    // R2 start pointer read/write
    wr(5'h08, 32'hCAFE_0040);
    rd(5'h08, v); check(v == 32'hCAFE_0040, "R2 start pointer readback", v, 32'hCAFE_0040);

    // R6 zero-length descriptor: no data access
    dc_cfg[0] = mk_cfg(2, 0, 2, 0); dc_src[0] = 32'h200; dc_dst[0] = 32'h800;
    dc_cnt[0] = 0; dc_par[0] = 32'h0;
    load_chain(1); start_chain(); wait_queue(idle);
    repeat (2) @(negedge clk);
    check(c_wr == 0, "R6 zero count writes", 32'(c_wr), 32'h0);
    check(c_half == 0, "R8 no half event on empty", 32'(c_half), 32'h0);
    verify_chain(1, "empty");

    // R9 wait cycles: 16 bytes as 4 word beats, 3 idle cycles between beats
    dc_cfg[0] = mk_cfg(2, 0, 2, 0); dc_src[0] = 32'h200; dc_dst[0] = 32'h840;
    dc_cnt[0] = 16; dc_par[0] = 32'h0000_5A03;
    load_chain(1); start_chain(); wait_queue(idle);
    check(idle == 9, "R9 idle cycles between beats", 32'(idle), 32'd9);
    verify_chain(1, "gap");
    check(c_half == 1, "R8 half event once", 32'(c_half), 32'd1);

    // R4 tail beats, R5 fixed source address
    dc_cfg[0] = mk_cfg(2, 0, 3, 0); dc_src[0] = 32'h240; dc_dst[0] = 32'h880;
    dc_cnt[0] = 7; dc_par[0] = 0;
    dc_cfg[1] = mk_cfg(1, 0, 2, 1); dc_src[1] = 32'h260; dc_dst[1] = 32'h8A0;
    dc_cnt[1] = 10; dc_par[1] = 1;
    load_chain(2); start_chain(); wait_queue(idle);
    verify_chain(2, "tail+io");
    check(c_half == 2, "R8 half events on chain", 32'(c_half), 32'd2);

    // R10 pause mid-descriptor
    dc_cfg[0] = mk_cfg(0, 0, 0, 0); dc_src[0] = 32'h300; dc_dst[0] = 32'h900;
    dc_cnt[0] = 200; dc_par[0] = 0;
    load_chain(1); start_chain();
    repeat (60) @(negedge clk);
    wr(5'h04, 32'h1);
    repeat (2) @(negedge clk);
    rd(5'h10, v); rd(5'h18, l1);
    nreq = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk); #2; if (mem_req) nreq++; end
    rd(5'h10, v2); rd(5'h18, l2);
    check(nreq == 0, "R10 no requests while paused", 32'(nreq), 32'h0);
    check(v2 == v, "R10 source held while paused", v2, v);
    check(l2 == l1 && l1 != 0, "R10 bytes left held while paused", l2, l1);
    wr(5'h04, 32'h0);
    wait_queue(idle);
    verify_chain(1, "pause");

    // R11 halt mid-descriptor
    dc_cfg[0] = mk_cfg(0, 0, 0, 0); dc_src[0] = 32'h300; dc_dst[0] = 32'hA00;
    dc_cnt[0] = 200; dc_par[0] = 0;
    load_chain(1); start_chain();
    repeat (40) @(negedge clk);
    wr(5'h00, 32'h0);
    repeat (3) @(negedge clk);
    c_pkg = 0; c_queue = 0; nreq = 0;
    rd(5'h18, l1);
    for (int k = 0; k < 30; k++) begin @(negedge clk); #2; if (mem_req) nreq++; end
    rd(5'h18, l2);
    check(nreq == 0, "R11 no requests after halt", 32'(nreq), 32'h0);
    check(c_pkg == 0 && c_queue == 0, "R11 no events after halt", 32'(c_pkg + c_queue), 32'h0);
    check(l2 == l1 && l1 != 0, "R11 progress kept after halt", l2, l1);
    rd(5'h00, v); check(v == 0, "R11 enable reads 0 after halt", v, 32'h0);
    for (int a = 12'h800; a < MEMSZ; a++) gold[a] = mem[a];

    // random chains with random acknowledge stalls (R12 handshake under stalls)
    stall_en = 1'b1;
    for (int t = 0; t < 10; t++) begin
      int n;
      n = 1 + int'($urandom % 3);
      for (int i = 0; i < n; i++) begin
        dc_cfg[i] = mk_cfg(int'($urandom % 4), int'($urandom % 2),
                           int'($urandom % 4), int'($urandom % 2));
        dc_src[i] = 32'h200 + ($urandom % 32'h180);
        dc_dst[i] = 32'h800 + 32'(i) * 32'h100 + ($urandom % 32'h80);
        dc_cnt[i] = 1 + ($urandom % 48);
        dc_par[i] = ($urandom & 32'hFF00) | ($urandom % 3);
      end
      load_chain(n); start_chain(); wait_queue(idle);
      verify_chain(n, "random R12");
      check(c_half == n, "R8 half count random", 32'(c_half), 32'(n));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule